// File: doc/BRIEF.md
# Nonvolatile Memory Access Controller

This controller sits on a small CPU register bus and gives software a way to read words from a read-only program store and to read or write single bytes in a data store. Five byte-wide registers are visible: two that together give an access address, two that together carry a data word, and one control register. The control register picks the target store, enables writes and holds the two start bits.

A read completes one clock after it is started. A data write latches its address and byte when it starts. It then runs for a fixed number of clocks, counted by an internal timer. At the end the stored byte is replaced and a one-cycle completion pulse is given. The start bits are set by software and cleared only by hardware. A write request is honoured only when writes are enabled and the data store is selected.

In this block the program store is a computed read-only table. The data store is a small internal byte array whose contents are not reset.

Top module: `nvm_access_ctrl`

## Requirements
- R1: After reset every register reads 0x00 and `wr_done` is 0.
- R2: Register offsets are 0 address-low, 1 address-high, 2 data-low, 3 data-high, 4 control. Address-high keeps only its low 5 bits and data-high keeps only its low 6 bits. The unused upper bits of both read as 0.
- R3: With control bit 7 set to 1 (program store), a read returns the word at address {address-high[4:0], address-low}. The word's bits 7:0 go to data-low and bits 13:8 go to data-high. The word stored at address a is (a*45 + 419) mod 16384.
- R4: With control bit 7 at 0 (data store), a read puts the byte at address-low into data-low. Address-high has no effect on the address, and data-high is left unchanged.
- R5: The read-start bit (control bit 0) and the write-start bit (control bit 1) are set by writing 1 to them. Writing 0 to them does not clear them. The read-start bit reads 1 for exactly one cycle, and the data registers are updated when it clears.
- R6: The write-enable bit (control bit 2) is 0 after reset. A write request made with it at 0 leaves the write-start bit at 0, gives no `wr_done` pulse and leaves the data store unchanged.
- R7: An enabled data write keeps the write-start bit at 1 for WR_CYCLES cycles (default 16). After that, the addressed byte holds the value that data-low had when the write started, and the old value is gone.
- R8: `wr_done` is high for exactly one cycle: the first cycle in which the write-start bit reads 0 again.
- R9: While a write is in progress, new read or write requests are ignored. The write in progress stores only the address and data it latched when it started.
- R10: A write request while the program store is selected has no effect: the write-start bit stays 0, no `wr_done` pulse is given and the data store is unchanged.
- R11: A control write that sets both start bits performs the read and drops the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset for read and write |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` (combinational) |
| wr_done | output | 1 | One-cycle pulse at the end of a data write |

## Verification
The assertions check on every cycle that the read-start bit clears itself after one cycle and that a write starts only with writes enabled and the data store selected. They also check that the completion pulse lines up with the clearing of the write-start bit and lasts one cycle, and that the latched write address and data stay stable while a write runs. Only the bench scenarios can show the data-facing results: the program words and byte values returned, the address and data bit formatting, and the exact write duration. They also show that ignored or dropped requests leave the stored bytes unchanged.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
   // register offsets on the CPU bus
   localparam logic [2:0] REG_ADR_LO = 3'd0;
   localparam logic [2:0] REG_ADR_HI = 3'd1;
   localparam logic [2:0] REG_DAT_LO = 3'd2;
   localparam logic [2:0] REG_DAT_HI = 3'd3;
   localparam logic [2:0] REG_CTRL   = 3'd4;

   // control register bit positions
   localparam int CB_RD  = 0;
   localparam int CB_WR  = 1;
   localparam int CB_EN  = 2;
   localparam int CB_SEL = 7;

   // program table coefficients
   localparam int ROM_MUL = 45;
   localparam int ROM_ADD = 419;
endpackage

// File: rtl/nvm_prog_rom.sv
module nvm_prog_rom
   import nvm_pkg::*;
#(
   parameter int ADDR_W     = 13,
   parameter int WORD_W     = 14,
   parameter int PROG_WORDS = 8192
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [WORD_W-1:0] word
);
   localparam int PAW = $clog2(PROG_WORDS);

   logic [ADDR_W-1:0] eff;

   generate
      if (PAW > ADDR_W) begin : g_bad_depth
         $error("PROG_WORDS exceeds the address space");
      end
      if (PAW == ADDR_W) begin : g_full
         assign eff = addr;
      end else begin : g_wrap
         assign eff = {{(ADDR_W-PAW){1'b0}}, addr[PAW-1:0]};
      end
   endgenerate

   logic [WORD_W+ADDR_W-1:0] prod;
   always_comb begin
      prod = {{WORD_W{1'b0}}, eff} * (WORD_W+ADDR_W)'(ROM_MUL)
           + (WORD_W+ADDR_W)'(ROM_ADD);
      word = prod[WORD_W-1:0];
   end
endmodule

// File: rtl/nvm_data_array.sv
module nvm_data_array #(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/nvm_write_timer.sv
module nvm_write_timer #(
   parameter int CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic fire,
   output logic done
);
   localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);

   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   assign fire = busy && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
         done <= 1'b0;
      end else begin
         done <= fire;
         if (fire) begin
            busy <= 1'b0;
         end else if (busy) begin
            cnt <= cnt - 1'b1;
         end else if (start) begin
            busy <= 1'b1;
            cnt  <= CW'(CYCLES - 1);
         end
      end
   end

   a_r7_hold_until_count: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt != '0) |=> busy);
endmodule

// File: rtl/nvm_access_ctrl.sv
module nvm_access_ctrl
   import nvm_pkg::*;
#(
   parameter int WR_CYCLES  = 16,
   parameter int PROG_WORDS = 8192,
   parameter int ADDR_W     = 13,
   parameter int WORD_W     = 14,
   parameter int DATA_AW    = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_we,
   input  logic [2:0] bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic       wr_done
);
   localparam int HI_ADR_W = ADDR_W - 8;
   localparam int HI_DAT_W = WORD_W - 8;

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_aw
         $error("ADDR_W must be 9..16");
      end
      if (WORD_W < 9 || WORD_W > 16) begin : g_bad_ww
         $error("WORD_W must be 9..16");
      end
      if (DATA_AW < 1 || DATA_AW > 8) begin : g_bad_daw
         $error("DATA_AW must be 1..8");
      end
   endgenerate

   logic [7:0]          adr_lo, dat_lo;
   logic [HI_ADR_W-1:0] adr_hi;
   logic [HI_DAT_W-1:0] dat_hi;
   logic                sel_q, wren_q, rd_go, rd_sel_q;
   logic [DATA_AW-1:0]  wr_addr_q;
   logic [7:0]          wr_data_q;
   logic                wr_busy, wr_fire;
   logic [WORD_W-1:0]   prog_word;
   logic [7:0]          mem_q;

   logic ctrl_wr, starts_ok, rd_req, wr_req;
   always_comb begin
      ctrl_wr   = bus_we && (bus_addr == REG_CTRL);
      starts_ok = ctrl_wr && !wr_busy && !rd_go;
      rd_req    = starts_ok && bus_wdata[CB_RD];
      wr_req    = starts_ok && bus_wdata[CB_WR] && !bus_wdata[CB_RD]
                  && bus_wdata[CB_EN] && !bus_wdata[CB_SEL];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adr_lo    <= '0;
         adr_hi    <= '0;
         dat_lo    <= '0;
         dat_hi    <= '0;
         sel_q     <= 1'b0;
         wren_q    <= 1'b0;
         rd_go     <= 1'b0;
         rd_sel_q  <= 1'b0;
         wr_addr_q <= '0;
         wr_data_q <= '0;
      end else begin
         if (bus_we) begin
            case (bus_addr)
               REG_ADR_LO: adr_lo <= bus_wdata;
               REG_ADR_HI: adr_hi <= bus_wdata[HI_ADR_W-1:0];
               REG_DAT_LO: dat_lo <= bus_wdata;
               REG_DAT_HI: dat_hi <= bus_wdata[HI_DAT_W-1:0];
               REG_CTRL: begin
                  sel_q  <= bus_wdata[CB_SEL];
                  wren_q <= bus_wdata[CB_EN];
               end
               default: ;
            endcase
         end
         rd_go <= rd_req;
         if (rd_req) rd_sel_q <= bus_wdata[CB_SEL];
         if (rd_go) begin
            if (rd_sel_q) begin
               dat_lo <= prog_word[7:0];
               dat_hi <= prog_word[WORD_W-1:8];
            end else begin
               dat_lo <= mem_q;
            end
         end
         if (wr_req) begin
            wr_addr_q <= adr_lo[DATA_AW-1:0];
            wr_data_q <= dat_lo;
         end
      end
   end

   always_comb begin
      case (bus_addr)
         REG_ADR_LO: bus_rdata = adr_lo;
         REG_ADR_HI: bus_rdata = {{(16-ADDR_W){1'b0}}, adr_hi};
         REG_DAT_LO: bus_rdata = dat_lo;
         REG_DAT_HI: bus_rdata = {{(16-WORD_W){1'b0}}, dat_hi};
         REG_CTRL:   bus_rdata = {sel_q, 4'b0000, wren_q, wr_busy, rd_go};
         default:    bus_rdata = 8'h00;
      endcase
   end

   nvm_prog_rom #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .PROG_WORDS(PROG_WORDS)) u_rom (
      .addr ({adr_hi, adr_lo}),
      .word (prog_word)
   );

   nvm_data_array #(.AW(DATA_AW), .DW(8)) u_data (
      .clk   (clk),
      .we    (wr_fire),
      .waddr (wr_addr_q),
      .wdata (wr_data_q),
      .raddr (adr_lo[DATA_AW-1:0]),
      .rdata (mem_q)
   );

   nvm_write_timer #(.CYCLES(WR_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (wr_req),
      .busy  (wr_busy),
      .fire  (wr_fire),
      .done  (wr_done)
   );

   a_r5_rd_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
      rd_go |=> !rd_go);
   a_r11_never_both: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_go && wr_busy));
   a_r6_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_busy) |-> (wren_q && !sel_q));
   a_r8_done_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_busy) |-> wr_done);
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |=> !wr_done);
   a_r9_latch_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_busy && $past(wr_busy)) |-> ($stable(wr_addr_q) && $stable(wr_data_q)));
endmodule

// File: tb/nvm_access_ctrl_test.sv
module nvm_access_ctrl_test;
   localparam int CLK_P = 10;
   localparam int WR_N  = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_we = 1'b0;
   logic [2:0] bus_addr = 3'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       wr_done;

   int checks = 0;
   int errors = 0;
   logic [7:0] model [256];
   bit         valid [256];

   always #(CLK_P/2) clk = ~clk;

   nvm_access_ctrl #(.WR_CYCLES(WR_N)) uut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wr_done(wr_done)
   );

   function automatic logic [13:0] pword(input int a);
      int m;
      m = a & 16'h1FFF;
      return 14'((m * 45 + 419) % 16384);
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic data_read(input int a, input string req);
      logic [7:0] v;
      bus_write(3'd0, 8'(a));
      bus_write(3'd4, 8'h05);
      @(negedge clk);
      rd(3'd2, v);
      chk(req, "data byte", v, model[a]);
   endtask

   task automatic prog_read(input int a, input logic [2:0] extra);
      logic [7:0] v;
      logic [13:0] w;
      w = pword(a);
      bus_write(3'd0, 8'(a));
      bus_write(3'd1, {extra, 5'(a >> 8)});
      bus_write(3'd4, 8'h81);
      rd(3'd4, v);
      chk("R5", "read-start set", int'(v[0]), 1);
      @(negedge clk);
      rd(3'd4, v);
      chk("R5", "read-start cleared", int'(v[0]), 0);
      rd(3'd2, v);
      chk("R3", "program low byte", v, w[7:0]);
      rd(3'd3, v);
      chk("R3", "program high byte", v, {2'b00, w[13:8]});
   endtask

   // checks write-start high for WR_N cycles and the done pulse
   task automatic do_write(input int a, input logic [7:0] d);
      logic [7:0] v;
      bit bad;
      bus_write(3'd0, 8'(a));
      bus_write(3'd2, d);
      bus_write(3'd4, 8'h06);
      rd(3'd4, v);
      chk("R7", "write-start set", int'(v[1]), 1);
      bad = 0;
      for (int k = 1; k <= WR_N; k++) begin
         @(negedge clk);
         rd(3'd4, v);
         if (k < WR_N) begin
            if (!v[1] || wr_done) bad = 1;
         end else begin
            chk("R8", "done at clear", int'(wr_done), 1);
            chk("R7", "write-start cleared", int'(v[1]), 0);
         end
      end
      chk("R7", "busy window", int'(bad), 0);
      @(negedge clk);
      chk("R8", "done one cycle", int'(wr_done), 0);
      model[a] = d;
      valid[a] = 1;
   endtask

   task automatic expect_no_write(input string req, input logic [7:0] ctl);
      logic [7:0] v;
      bit seen;
      bus_write(3'd4, ctl);
      rd(3'd4, v);
      chk(req, "write-start stays 0", int'(v[1]), 0);
      seen = 0;
      for (int k = 0; k < WR_N + 3; k++) begin
         @(negedge clk);
         if (wr_done) seen = 1;
      end
      chk(req, "no done pulse", int'(seen), 0);
   endtask

   initial begin
      #(CLK_P * 150000);
      errors++;
      $display("FAIL R7 watchdog expired: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] v;
      void'($urandom(32'd4321));
      for (int i = 0; i < 256; i++) valid[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int r = 0; r < 5; r++) begin
         rd(3'(r), v);
         chk("R1", "reset register", v, 0);
      end
      chk("R1", "reset done", int'(wr_done), 0);

      // R2 formatting
      bus_write(3'd1, 8'hFF);
      rd(3'd1, v);
      chk("R2", "address-high mask", v, 8'h1F);
      bus_write(3'd3, 8'hFF);
      rd(3'd3, v);
      chk("R2", "data-high mask", v, 8'h3F);
      bus_write(3'd0, 8'hA7);
      rd(3'd0, v);
      chk("R2", "address-low", v, 8'hA7);

      // R3 program reads at corners
      prog_read(0, 3'b000);
      prog_read(16'h1FFF, 3'b111);
      prog_read(16'h0100, 3'b010);

      // R7 writes
      do_write(8'h10, 8'h5A);
      data_read(8'h10, "R7");
      do_write(8'h10, 8'hC3);
      data_read(8'h10, "R7");
      do_write(8'hFF, 8'h01);

      // R4 address-high ignored, data-high unchanged
      bus_write(3'd3, 8'h2A);
      bus_write(3'd1, 8'h1F);
      data_read(8'h10, "R4");
      rd(3'd3, v);
      chk("R4", "data-high unchanged", v, 8'h2A);

      // R6 write with enable 0
      bus_write(3'd0, 8'h10);
      bus_write(3'd2, 8'h99);
      expect_no_write("R6", 8'h02);
      rd(3'd4, v);
      chk("R6", "enable reads 0", int'(v[2]), 0);
      data_read(8'h10, "R6");

      // R10 write while program store selected
      bus_write(3'd0, 8'h10);
      bus_write(3'd2, 8'h77);
      expect_no_write("R10", 8'h86);
      data_read(8'h10, "R10");

      // R11 both start bits: read done, write dropped
      bus_write(3'd0, 8'h10);
      bus_write(3'd2, 8'h44);
      bus_write(3'd4, 8'h07);
      rd(3'd4, v);
      chk("R11", "read started, write dropped", v & 8'h03, 8'h01);
      @(negedge clk);
      rd(3'd2, v);
      chk("R11", "read value", v, model[8'h10]);
      expect_no_write("R11", 8'h04);
      data_read(8'h10, "R11");

      // R9 and R5: requests during a write are ignored
      bus_write(3'd0, 8'h20);
      bus_write(3'd2, 8'hE1);
      bus_write(3'd4, 8'h06);
      bus_write(3'd2, 8'h1E);
      bus_write(3'd4, 8'h07);
      rd(3'd4, v);
      chk("R9", "read ignored while busy", v & 8'h03, 8'h02);
      bus_write(3'd4, 8'h04);
      rd(3'd4, v);
      chk("R5", "write-start not cleared by 0", int'(v[1]), 1);
      begin
         int n = 0;
         while (!wr_done && n < 100) begin
            @(negedge clk);
            n++;
         end
         chk("R9", "write completed at original time", n, WR_N - 3);
      end
      @(negedge clk);
      rd(3'd2, v);
      chk("R9", "data-low not reloaded", v, 8'h1E);
      model[8'h20] = 8'hE1;
      valid[8'h20] = 1;
      data_read(8'h20, "R9");

      // random mix
      for (int i = 0; i < 40; i++) begin
         int op, a;
         op = int'($urandom % 3);
         a  = int'($urandom % 256);
         if (op == 0) do_write(a, 8'($urandom));
         else if (op == 1 && valid[a]) data_read(a, "R4");
         else prog_read(int'($urandom % 8192), 3'($urandom));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule